// File: doc/BRIEF.md
# Four-Wide In-Order Retirement Controller

This block sits at the head of a reorder buffer and decides, each clock, how many of the four oldest entries leave the speculative window. It looks at each candidate's valid, completed, store and exception flags. It retires a contiguous run starting at the oldest slot and stops at the first entry that is incomplete or faulting, or at a second store. Retiring entries drive one register-file write port per slot. The block raises a single commit strobe toward the store buffer when the group holds a store. It then moves the reorder-buffer head and the architectural instruction pointer forward.

Exceptions and external interrupts are recognised only at the boundary that the current group leaves behind. A faulting entry never retires. The cycle after it reaches the front of the group, the controller asserts a pipeline flush and reports the faulting instruction's address. A pending interrupt, whether held on the input or latched from an earlier pulse, lets the current group finish. The next cycle it flushes and reports the next sequential instruction pointer. Nothing retires while the flush is asserted, because every younger entry is being discarded.

Top module: `retire_ctrl`

## Requirements
- R1: Slot i retires only if every slot 0..i is valid, completed and free of the exception flag. The retiring slots always form a contiguous run from slot 0, and `retire_cnt_o` (0 to 4) equals its length.
- R2: A group never holds two stores. A second store and every younger slot wait for a later cycle. `st_commit_o` is 1 exactly when one retiring slot carries the store flag.
- R3: For each retiring slot with its write flag set, `rf_we_o[i]` is 1, and `rf_addr_o[i]` / `rf_data_o[i]` carry that slot's register index and result. Non-retiring slots have `rf_we_o[i]` = 0.
- R4: When two retiring slots with write flags name the same register, only the younger (higher-numbered) slot's write enable is asserted.
- R5: On each clock edge `head_o` advances by the retire count, modulo the buffer depth (16 by default). It starts at 0 after reset.
- R6: After a non-empty group, `arch_ip_o` takes the next-sequential address of the youngest retired entry one cycle later. It is unchanged when nothing retires and is 0x1000 after reset.
- R7: If the first non-retiring slot is valid, completed and flagged with an exception, the next cycle shows `flush_o` = 1 and `exc_o` = 1, with `flush_ip_o` equal to that slot's instruction address. The faulting entry does not retire.
- R8: An interrupt is pending while `irq_i` is 1 or after any earlier pulse that has not yet been taken. It is taken at the end of the current group, and the next cycle shows `flush_o` = 1 and `irq_taken_o` = 1, with `flush_ip_o` equal to the post-group `arch_ip_o`. An exception in the same cycle wins, and the interrupt stays pending.
- R9: In a cycle with `flush_o` = 1, the retire count is 0, no write enable or store commit is asserted, and no new flush is raised for the following cycle.
- R10: During and right after reset, `flush_o`, `exc_o` and `irq_taken_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ent_valid_i | input | 4 | Candidate slot holds an entry (slot 0 oldest) |
| ent_done_i | input | 4 | Entry has completed execution |
| ent_store_i | input | 4 | Entry is a store |
| ent_exc_i | input | 4 | Entry faulted |
| ent_wen_i | input | 4 | Entry writes a register |
| ent_rd_i | input | 4x5 | Destination register index per slot |
| ent_data_i | input | 4x32 | Result per slot |
| ent_ip_i | input | 4x32 | Instruction address per slot |
| ent_nip_i | input | 4x32 | Next-sequential address per slot |
| irq_i | input | 1 | External interrupt request (level or pulse) |
| retire_cnt_o | output | 3 | Entries retiring this cycle |
| rf_we_o | output | 4 | Register write enable per port |
| rf_addr_o | output | 4x5 | Register index per port |
| rf_data_o | output | 4x32 | Write data per port |
| st_commit_o | output | 1 | One store commits this cycle |
| head_o | output | 4 | Reorder-buffer head pointer |
| arch_ip_o | output | 32 | Architectural instruction pointer |
| flush_o | output | 1 | Pipeline flush |
| flush_ip_o | output | 32 | Restart/report address for the flush |
| exc_o | output | 1 | Flush caused by an exception |
| irq_taken_o | output | 1 | Flush caused by an interrupt |

## Verification
The checker assumes the reorder buffer clears its candidate slots in the flush cycle, or at least that the block's own outputs ignore them. It also assumes the exception flag matters only on completed entries. The directed stimulus changes inputs only on falling edges. In the flush cycle it deliberately presents completed entries, including a store, so that the quiet-output rule is tested against real candidates. Interrupt pulses last a single cycle, so a held level never retriggers after it is taken. The one exception is the priority case, where the bench depends on the latch to hold the request across the exception flush.

// File: rtl/retire_pkg.sv
package retire_pkg;
  typedef enum logic [1:0] {
    FL_NONE = 2'd0,
    FL_EXC  = 2'd1,
    FL_IRQ  = 2'd2
  } flush_e;
endpackage

// File: rtl/retire_select.sv
module retire_select #(
  parameter int SLOTS = 4,
  localparam int CW = $clog2(SLOTS + 1),
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          en_i,
  input  logic [SLOTS-1:0] valid_i,
  input  logic [SLOTS-1:0] done_i,
  input  logic [SLOTS-1:0] store_i,
  input  logic [SLOTS-1:0] exc_i,
  output logic [SLOTS-1:0] mask_o,
  output logic [CW-1:0]    cnt_o,
  output logic             exc_hit_o,
  output logic [SW-1:0]    exc_slot_o
);
  logic go, seen_st;

  always_comb begin
    go         = en_i;
    seen_st    = 1'b0;
    mask_o     = '0;
    cnt_o      = '0;
    exc_hit_o  = 1'b0;
    exc_slot_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (go) begin
        if (valid_i[i] && done_i[i] && !exc_i[i] && !(store_i[i] && seen_st)) begin
          mask_o[i] = 1'b1;
          cnt_o     = cnt_o + CW'(1);
          seen_st   = seen_st | store_i[i];
        end else begin
          go = 1'b0;
          // faulting entry is now the oldest unretired one
          if (valid_i[i] && done_i[i] && exc_i[i]) begin
            exc_hit_o  = 1'b1;
            exc_slot_o = SW'(i);
          end
        end
      end
    end
  end
endmodule

// File: rtl/retire_wmask.sv
module retire_wmask #(
  parameter int SLOTS = 4,
  parameter int RW = 5
) (
  input  logic [SLOTS-1:0]         mask_i,
  input  logic [SLOTS-1:0]         wen_i,
  input  logic [SLOTS-1:0][RW-1:0] rd_i,
  output logic [SLOTS-1:0]         we_o
);
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      we_o[i] = mask_i[i] & wen_i[i];
      for (int j = i + 1; j < SLOTS; j++) begin
        if (mask_i[j] && wen_i[j] && (rd_i[j] == rd_i[i])) we_o[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl #(
  parameter int          SLOTS    = 4,
  parameter int          DEPTH    = 16,
  parameter int          RW       = 5,
  parameter int          DW       = 32,
  parameter int          IPW      = 32,
  parameter logic [31:0] RESET_IP = 32'h0000_1000,
  localparam int HW = $clog2(DEPTH),
  localparam int CW = $clog2(SLOTS + 1),
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [SLOTS-1:0]          ent_valid_i,
  input  logic [SLOTS-1:0]          ent_done_i,
  input  logic [SLOTS-1:0]          ent_store_i,
  input  logic [SLOTS-1:0]          ent_exc_i,
  input  logic [SLOTS-1:0]          ent_wen_i,
  input  logic [SLOTS-1:0][RW-1:0]  ent_rd_i,
  input  logic [SLOTS-1:0][DW-1:0]  ent_data_i,
  input  logic [SLOTS-1:0][IPW-1:0] ent_ip_i,
  input  logic [SLOTS-1:0][IPW-1:0] ent_nip_i,
  input  logic                      irq_i,
  output logic [CW-1:0]             retire_cnt_o,
  output logic [SLOTS-1:0]          rf_we_o,
  output logic [SLOTS-1:0][RW-1:0]  rf_addr_o,
  output logic [SLOTS-1:0][DW-1:0]  rf_data_o,
  output logic                      st_commit_o,
  output logic [HW-1:0]             head_o,
  output logic [IPW-1:0]            arch_ip_o,
  output logic                      flush_o,
  output logic [IPW-1:0]            flush_ip_o,
  output logic                      exc_o,
  output logic                      irq_taken_o
);
  import retire_pkg::*;

  flush_e          cause_q;
  logic [HW-1:0]   head_q;
  logic [IPW-1:0]  arch_ip_q, flush_ip_q, last_nip;
  logic            irq_lat_q;
  logic [SLOTS-1:0] ret_mask;
  logic [CW-1:0]   cnt;
  logic            exc_hit;
  logic [SW-1:0]   exc_slot;
  logic            irq_pend, take_irq, take_exc;
  logic [HW:0]     head_sum;
  logic [HW-1:0]   head_nxt;

  assign flush_o = (cause_q != FL_NONE);

  retire_select #(.SLOTS(SLOTS)) u_sel (
    .en_i      (!flush_o),
    .valid_i   (ent_valid_i),
    .done_i    (ent_done_i),
    .store_i   (ent_store_i),
    .exc_i     (ent_exc_i),
    .mask_o    (ret_mask),
    .cnt_o     (cnt),
    .exc_hit_o (exc_hit),
    .exc_slot_o(exc_slot)
  );

  retire_wmask #(.SLOTS(SLOTS), .RW(RW)) u_wm (
    .mask_i(ret_mask),
    .wen_i (ent_wen_i),
    .rd_i  (ent_rd_i),
    .we_o  (rf_we_o)
  );

  assign rf_addr_o    = ent_rd_i;
  assign rf_data_o    = ent_data_i;
  assign retire_cnt_o = cnt;
  assign st_commit_o  = |(ret_mask & ent_store_i);

  always_comb begin
    last_nip = arch_ip_q;
    for (int i = 0; i < SLOTS; i++) begin
      if (ret_mask[i]) last_nip = ent_nip_i[i];
    end
  end

  assign irq_pend = irq_i | irq_lat_q;
  assign take_exc = exc_hit;  // exc_hit already gated by flush
  assign take_irq = irq_pend & !flush_o & !exc_hit;

  assign head_sum = {1'b0, head_q} + (HW+1)'(cnt);
  assign head_nxt = (head_sum >= (HW+1)'(DEPTH)) ? HW'(head_sum - (HW+1)'(DEPTH))
                                                 : HW'(head_sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q    <= FL_NONE;
      head_q     <= '0;
      arch_ip_q  <= IPW'(RESET_IP);
      flush_ip_q <= '0;
      irq_lat_q  <= 1'b0;
    end else begin
      head_q    <= head_nxt;
      arch_ip_q <= last_nip;
      irq_lat_q <= irq_pend & !take_irq;
      if (take_exc) begin
        cause_q    <= FL_EXC;
        flush_ip_q <= ent_ip_i[exc_slot];
      end else if (take_irq) begin
        cause_q    <= FL_IRQ;
        flush_ip_q <= last_nip;
      end else begin
        cause_q <= FL_NONE;
      end
    end
  end

  assign head_o      = head_q;
  assign arch_ip_o   = arch_ip_q;
  assign flush_ip_o  = flush_ip_q;
  assign exc_o       = (cause_q == FL_EXC);
  assign irq_taken_o = (cause_q == FL_IRQ);
endmodule

// File: rtl/retire_ctrl_chk.sv
module retire_ctrl_chk #(
  parameter int SLOTS = 4,
  parameter int DEPTH = 16,
  parameter int RW = 5,
  localparam int HW = $clog2(DEPTH),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [SLOTS-1:0]         ret_mask,
  input logic [SLOTS-1:0]         ent_store_i,
  input logic [SLOTS-1:0]         rf_we_o,
  input logic [SLOTS-1:0][RW-1:0] rf_addr_o,
  input logic [CW-1:0]            retire_cnt_o,
  input logic                     st_commit_o,
  input logic [HW-1:0]            head_o,
  input logic                     flush_o,
  input logic                     exc_o,
  input logic                     irq_taken_o
);
  logic          seen_q;
  logic [HW-1:0] head_exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      head_exp_q <= '0;
    end else begin
      seen_q     <= 1'b1;
      head_exp_q <= HW'((32'(head_o) + 32'(retire_cnt_o)) % DEPTH);
    end
  end

  a_r1_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_mask & SLOTS'(ret_mask + SLOTS'(1))) == '0);

  a_r2_one_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ret_mask & ent_store_i) <= 1);

  a_r3_we_in_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o & ~ret_mask) == '0);

  for (genvar i = 0; i < SLOTS; i++) begin : g_pi
    for (genvar j = i + 1; j < SLOTS; j++) begin : g_pj
      a_r4_unique_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rf_we_o[i] && rf_we_o[j]) |-> (rf_addr_o[i] != rf_addr_o[j]));
    end
  end

  a_r5_head_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (head_o == head_exp_q));

  a_r7_cause_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (flush_o && !irq_taken_o));

  a_r9_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (retire_cnt_o == '0 && rf_we_o == '0 && !st_commit_o));

  a_r9_single_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
endmodule

bind retire_ctrl retire_ctrl_chk #(.SLOTS(SLOTS), .DEPTH(DEPTH), .RW(RW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ret_mask    (ret_mask),
  .ent_store_i (ent_store_i),
  .rf_we_o     (rf_we_o),
  .rf_addr_o   (rf_addr_o),
  .retire_cnt_o(retire_cnt_o),
  .st_commit_o (st_commit_o),
  .head_o      (head_o),
  .flush_o     (flush_o),
  .exc_o       (exc_o),
  .irq_taken_o (irq_taken_o)
);

// File: tb/retire_ctrl_test.sv
module retire_ctrl_test;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        valid, done, store, exc, wen;
  logic [3:0][4:0]   rd;
  logic [3:0][31:0]  data, ip, nip;
  logic              irq;
  logic [2:0]        cnt;
  logic [3:0]        we;
  logic [3:0][4:0]   waddr;
  logic [3:0][31:0]  wdata;
  logic              st_commit, flush, exc_f, irq_tk;
  logic [3:0]        head;
  logic [31:0]       arch_ip, flush_ip;

  int n_chk = 0, n_err = 0;
  int exp_head = 0;
  logic [31:0] exp_ip = 32'h1000;

  always #5 clk = ~clk;

  retire_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ent_valid_i(valid), .ent_done_i(done), .ent_store_i(store), .ent_exc_i(exc),
    .ent_wen_i(wen), .ent_rd_i(rd), .ent_data_i(data), .ent_ip_i(ip), .ent_nip_i(nip),
    .irq_i(irq),
    .retire_cnt_o(cnt), .rf_we_o(we), .rf_addr_o(waddr), .rf_data_o(wdata),
    .st_commit_o(st_commit), .head_o(head), .arch_ip_o(arch_ip),
    .flush_o(flush), .flush_ip_o(flush_ip), .exc_o(exc_f), .irq_taken_o(irq_tk)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    valid = '0; done = '0; store = '0; exc = '0; wen = '0;
    rd = '0; data = '0; ip = '0; nip = '0;
  endtask

  task automatic put(input int i, input bit d, input bit s, input bit e, input bit w,
                     input logic [4:0] r, input logic [31:0] a);
    valid[i] = 1'b1; done[i] = d; store[i] = s; exc[i] = e; wen[i] = w;
    rd[i] = r; data[i] = a ^ 32'hA5A5_0000; ip[i] = a; nip[i] = a + 32'd4;
  endtask

  // check comb count, cross edge, check head/ip
  task automatic step(input string tag, input int exp_cnt);
    #1;
    chk({tag, " cnt"}, 64'(cnt), 64'(exp_cnt));
    if (exp_cnt > 0) exp_ip = nip[exp_cnt-1];
    exp_head = (exp_head + exp_cnt) % 16;
    @(posedge clk); #1;
    chk("R5 head", 64'(head), 64'(exp_head));
    chk("R6 arch_ip", 64'(arch_ip), 64'(exp_ip));
  endtask

  task automatic t_reset();
    chk("R5 head reset", 64'(head), 64'd0);
    chk("R6 ip reset", 64'(arch_ip), 64'h1000);
    chk("R10 flush reset", 64'({flush, exc_f, irq_tk}), 64'd0);
  endtask

  task automatic t_full();
    @(negedge clk); clr();
    for (int i = 0; i < 4; i++) put(i, 1, 0, 0, 1, 5'(i + 1), 32'h2000 + 32'(4 * i));
    #1;
    chk("R3 we full", 64'(we), 64'hF);
    chk("R3 addr slot3", 64'(waddr[3]), 64'd4);
    chk("R3 data slot2", 64'(wdata[2]), 64'(32'h2008 ^ 32'hA5A5_0000));
    chk("R2 no store", 64'(st_commit), 64'd0);
    step("R1 full", 4);
  endtask

  task automatic t_incomplete();
    @(negedge clk); clr();
    put(0, 1, 0, 0, 1, 5'd1, 32'h3000);
    put(1, 1, 0, 0, 0, 5'd2, 32'h3004);
    put(2, 0, 0, 0, 1, 5'd3, 32'h3008);
    put(3, 1, 0, 0, 1, 5'd4, 32'h300c);
    #1 chk("R3 we partial", 64'(we), 64'b0001);
    step("R1 incomplete", 2);
    @(negedge clk); clr();
    put(0, 0, 0, 0, 1, 5'd3, 32'h3008);
    put(1, 1, 0, 0, 1, 5'd4, 32'h300c);
    #1 chk("R3 we none", 64'(we), 64'd0);
    step("R1 head not done", 0);
  endtask

  task automatic t_stores();
    @(negedge clk); clr();
    put(0, 1, 1, 0, 0, 5'd0, 32'h4000);
    put(1, 1, 0, 0, 1, 5'd6, 32'h4004);
    put(2, 1, 1, 0, 0, 5'd0, 32'h4008);
    put(3, 1, 0, 0, 1, 5'd7, 32'h400c);
    #1 chk("R2 commit A", 64'(st_commit), 64'd1);
    step("R2 second store", 2);
    @(negedge clk); clr();
    put(0, 1, 1, 0, 0, 5'd0, 32'h4008);
    put(1, 1, 1, 0, 0, 5'd0, 32'h400c);
    #1 chk("R2 commit B", 64'(st_commit), 64'd1);
    step("R2 back-to-back", 1);
    @(negedge clk); clr();
    put(0, 1, 0, 0, 1, 5'd1, 32'h400c);
    put(1, 1, 0, 0, 1, 5'd2, 32'h4010);
    put(2, 1, 0, 0, 1, 5'd3, 32'h4014);
    put(3, 1, 1, 0, 0, 5'd0, 32'h4018);
    #1 chk("R2 commit C", 64'(st_commit), 64'd1);
    step("R2 single store last", 4);
  endtask

  task automatic t_same_rd();
    @(negedge clk); clr();
    put(0, 1, 0, 0, 1, 5'd5, 32'h5000);
    put(1, 1, 0, 0, 1, 5'd3, 32'h5004);
    put(2, 1, 0, 0, 1, 5'd5, 32'h5008);
    put(3, 1, 0, 0, 0, 5'd5, 32'h500c);
    #1 chk("R4 younger wins", 64'(we), 64'b0110);
    step("R4 group", 4);
  endtask

  task automatic t_exc();
    @(negedge clk); clr();
    put(0, 1, 0, 0, 1, 5'd1, 32'h6000);
    put(1, 1, 0, 0, 1, 5'd2, 32'h6004);
    put(2, 1, 0, 1, 1, 5'd3, 32'h6008);
    put(3, 1, 0, 0, 1, 5'd4, 32'h600c);
    #1 chk("R7 we before fault", 64'(we), 64'b0011);
    step("R7 stop at fault", 2);
    chk("R7 flush", 64'({flush, exc_f, irq_tk}), 64'b110);
    chk("R7 flush_ip", 64'(flush_ip), 64'h6008);
    @(negedge clk); clr();
    for (int i = 0; i < 4; i++) put(i, 1, (i == 1), 0, 1, 5'(i + 8), 32'h7000 + 32'(4 * i));
    #1 chk("R9 quiet we/st", 64'({we, st_commit}), 64'd0);
    step("R9 quiet cnt", 0);
    chk("R9 no refire", 64'(flush), 64'd0);
  endtask

  task automatic t_irq();
    @(negedge clk); clr(); irq = 1'b1;
    put(0, 1, 0, 0, 1, 5'd1, 32'h8000);
    put(1, 1, 1, 0, 0, 5'd0, 32'h8004);
    put(2, 1, 0, 0, 1, 5'd2, 32'h8008);
    step("R8 group completes", 3);
    chk("R8 irq flush", 64'({flush, exc_f, irq_tk}), 64'b101);
    chk("R8 flush_ip", 64'(flush_ip), 64'h800c);
    @(negedge clk); clr(); irq = 1'b0;
    step("R9 irq flush cycle", 0);
    chk("R8 single take", 64'(flush), 64'd0);
  endtask

  task automatic t_irq_vs_exc();
    @(negedge clk); clr(); irq = 1'b1;
    put(0, 1, 0, 1, 1, 5'd1, 32'h9000);
    step("R8 exc priority", 0);
    chk("R8 exc wins", 64'({flush, exc_f, irq_tk}), 64'b110);
    chk("R7 flush_ip head", 64'(flush_ip), 64'h9000);
    @(negedge clk); clr(); irq = 1'b0;
    step("R9 exc flush cycle", 0);
    chk("R9 gap", 64'(flush), 64'd0);
    @(negedge clk); clr();
    step("R8 latched", 0);
    chk("R8 latched take", 64'({flush, exc_f, irq_tk}), 64'b101);
    chk("R8 latched ip", 64'(flush_ip), 64'(exp_ip));
    @(negedge clk); clr();
    step("R8 done", 0);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); clr();
      for (int i = 0; i < 3; i++) put(i, 1, 0, 0, 1, 5'(i), 32'hA000 + 32'(16 * k + 4 * i));
      step("R5 wrap", 3);
    end
  endtask

  initial begin
    clr(); irq = 1'b0;
    #22 rst_n = 1'b1;
    #1 t_reset();
    t_full();
    t_incomplete();
    t_stores();
    t_same_rd();
    t_exc();
    t_irq();
    t_irq_vs_exc();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule